// File: doc/BRIEF.md
# Ping-Pong Gamma Lookup Table

This block applies a per-channel gamma curve to a stream of RGB pixels. It holds two complete tables, A and B, and each has 256 entries of 12-bit unsigned fraction (u0.12) for each of red, green and blue. The pixel stream looks up each channel in the table that is currently applied. A bypass mode passes the pixel through instead. While one table feeds the pixels, the host reloads the other. At a start-of-frame strobe the host then swaps over to the reloaded table, so a frame never mixes two curves.

The host loads a table through a small sequencer. It first sets a start index. It then pushes data words through a single data port. The words go red, green, blue for that index, and after the blue word the index moves up by one. A 3-bit mask can spare any channel from being written. A select bit chooses the table that receives the writes. A status output reports which table is applied, so software can always load the idle one.

Pixels enter and leave on valid/ready handshakes. A pixel is taken on any cycle where `pix_valid` and `pix_ready` are both high. Its result appears on the next cycle with `out_valid` high. The result holds steady until `out_ready` takes it. `pix_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure reaches the input with no added delay.

Top module: `gamma_lut_pingpong`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `lut_status` is 0, which means bypass is applied.
- R2: Loading `host_idx` with `host_idx_load` sets the write index and restarts the colour phase at red. Each `host_data_wr` writes the next colour of the current index in the order red, green, blue. The blue word advances the index by one, and index 255 wraps to 0. When both strobes are high in the same cycle, the index load wins and the data word is dropped.
- R3: `host_wr_mask` bit 0 enables red, bit 1 green and bit 2 blue. When a masked colour's turn comes, its entry is left unchanged, but the phase and index still advance as if it had been written.
- R4: `host_ram_sel` = 0 sends host writes to table A and 1 sends them to table B.
- R5: In mode 2 each output channel is the table-A entry addressed by the upper 8 bits of that input channel. In mode 3 it is the table-B entry. The lower input bits are ignored.
- R6: `mode_req` takes effect only on a cycle where `frame_start` is high. Pixels taken in that cycle or earlier use the previously applied mode.
- R7: `lut_status` reads 1 while mode 2 is applied and 2 while mode 3 is applied. It reads 0 while code 0 or code 1 is applied, and both of those codes mean bypass. It follows the applied mode, never a pending request.
- R8: In bypass each output channel is the upper 8 input bits followed by four zero bits.
- R9: A pixel taken at a clock edge appears at the output just after that same edge, with `out_valid` high.
- R10: `pix_ready` equals not `out_valid`, or `out_ready`. While `out_valid` is high and `out_ready` is low, the outputs hold steady and no new pixel is taken.
- R11: Host writes to the table that is not applied do not change the pixel outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_idx_load | input | 1 | Load the write index from host_idx |
| host_idx | input | 8 | Start index for a burst of writes |
| host_data_wr | input | 1 | Write one colour word |
| host_data | input | 12 | u0.12 table entry |
| host_wr_mask | input | 3 | Per-colour write enable (bit0 R, bit1 G, bit2 B) |
| host_ram_sel | input | 1 | Destination table: 0 A, 1 B |
| mode_req | input | 2 | Requested mode: 0/1 bypass, 2 table A, 3 table B |
| frame_start | input | 1 | Start-of-frame strobe that applies mode_req |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Input pixel accepted this cycle when valid |
| pix_r | input | IN_W | Red component |
| pix_g | input | IN_W | Green component |
| pix_b | input | IN_W | Blue component |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |
| lut_status | output | 2 | Applied table: 0 bypass, 1 A, 2 B |

## Verification
The assertions assume that the host never raises `host_idx_load` and `host_data_wr` together when it expects the data word to land. They also assume that `out_ready` and `pix_valid` are driven to known levels from reset onward. The stimulus changes every input a short time after the falling clock edge and leaves the index-load and data strobes on separate cycles. Before any pixel is read in mode 2 or 3, it fills every entry of both tables. As a result, no lookup ever reads an entry that has never been written.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    LM_BYPASS = 2'd0,
    LM_RSVD   = 2'd1,
    LM_TAB_A  = 2'd2,
    LM_TAB_B  = 2'd3
  } lut_mode_e;

  localparam logic [1:0] ST_BYPASS = 2'd0;
  localparam logic [1:0] ST_TAB_A  = 2'd1;
  localparam logic [1:0] ST_TAB_B  = 2'd2;
endpackage

// File: rtl/gamma_host_seq.sv
module gamma_host_seq #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12,
  parameter int CH     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       idx_load,
  input  logic [IDX_W-1:0]           idx_val,
  input  logic                       data_wr,
  input  logic [DATA_W-1:0]          data_in,
  input  logic [CH-1:0]              wr_mask,
  input  logic                       ram_sel,
  output logic [1:0][CH-1:0]         wr_en,
  output logic [IDX_W-1:0]           wr_addr,
  output logic [DATA_W-1:0]          wr_data
);
  localparam int PH_W = (CH > 1) ? $clog2(CH) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CH - 1);

  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= '0;
    end else if (idx_load) begin
      idx   <= idx_val;
      phase <= '0;
    end else if (data_wr) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        idx   <= idx + IDX_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  always_comb begin
    wr_en = '0;
    if (data_wr && !idx_load && wr_mask[phase])
      wr_en[ram_sel][phase] = 1'b1;
  end

  assign wr_addr = idx;
  assign wr_data = data_in;

  // R2
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_load && phase == PH_LAST) |=> (idx == $past(idx) + IDX_W'(1)));
  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_LAST);
  // R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/gamma_bank.sv
module gamma_bank #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12,
  parameter int CH     = 3
) (
  input  logic                         clk,
  input  logic [CH-1:0]                wr_en,
  input  logic [IDX_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [CH-1:0][IDX_W-1:0]     rd_addr,
  output logic [CH-1:0][DATA_W-1:0]    rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en[c]) mem[wr_addr] <= wr_data;
      if (rd_en)    q <= mem[rd_addr[c]];
    end

    assign rd_data[c] = q;
  end
endmodule

// File: rtl/gamma_lut_pingpong.sv
module gamma_lut_pingpong
  import gamma_lut_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_idx_load,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic              host_data_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic [2:0]        host_wr_mask,
  input  logic              host_ram_sel,
  input  logic [1:0]        mode_req,
  input  logic              frame_start,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [IN_W-1:0]   pix_r,
  input  logic [IN_W-1:0]   pix_g,
  input  logic [IN_W-1:0]   pix_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_r,
  output logic [DATA_W-1:0] out_g,
  output logic [DATA_W-1:0] out_b,
  output logic [1:0]        lut_status
);
  localparam int PAD_W = DATA_W - IDX_W;

  lut_mode_e                         active_mode, sel_q;
  logic                              accept;
  logic [NUM_CH-1:0][IDX_W-1:0]      pix_idx;
  logic [NUM_CH-1:0][DATA_W-1:0]     byp_q;
  logic [NUM_CH-1:0][DATA_W-1:0]     res;
  logic [1:0][NUM_CH-1:0]            wr_en;
  logic [1:0][NUM_CH-1:0][DATA_W-1:0] bank_q;
  logic [IDX_W-1:0]                  wr_addr;
  logic [DATA_W-1:0]                 wr_data;

  assign pix_idx[0] = pix_r[IN_W-1 -: IDX_W];
  assign pix_idx[1] = pix_g[IN_W-1 -: IDX_W];
  assign pix_idx[2] = pix_b[IN_W-1 -: IDX_W];

  assign pix_ready = !out_valid || out_ready;
  assign accept    = pix_valid && pix_ready;

  gamma_host_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CH(NUM_CH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_load (host_idx_load),
    .idx_val  (host_idx),
    .data_wr  (host_data_wr),
    .data_in  (host_data),
    .wr_mask  (host_wr_mask),
    .ram_sel  (host_ram_sel),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gamma_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CH(NUM_CH)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en[b]),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (accept),
      .rd_addr (pix_idx),
      .rd_data (bank_q[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_mode <= LM_BYPASS;
    else if (frame_start) active_mode <= lut_mode_e'(mode_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sel_q     <= LM_BYPASS;
      byp_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      sel_q     <= active_mode;
      for (int c = 0; c < NUM_CH; c++) byp_q[c] <= {pix_idx[c], {PAD_W{1'b0}}};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel_q)
      LM_TAB_A: res = bank_q[0];
      LM_TAB_B: res = bank_q[1];
      default:  res = byp_q;
    endcase
  end

  assign out_r = res[0];
  assign out_g = res[1];
  assign out_b = res[2];

  always_comb begin
    unique case (active_mode)
      LM_TAB_A: lut_status = ST_TAB_A;
      LM_TAB_B: lut_status = ST_TAB_B;
      default:  lut_status = ST_BYPASS;
    endcase
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));
  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> out_valid);
  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(lut_status));
  // R7
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lut_status != 2'd3);
endmodule

// File: tb/gamma_lut_pingpong_test.sv
module gamma_lut_pingpong_test;
  localparam int IN_W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_idx_load = 1'b0;
  logic [7:0]  host_idx = '0;
  logic        host_data_wr = 1'b0;
  logic [11:0] host_data = '0;
  logic [2:0]  host_wr_mask = 3'd7;
  logic        host_ram_sel = 1'b0;
  logic [1:0]  mode_req = 2'd0;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [IN_W-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_r, out_g, out_b;
  logic [1:0]  lut_status;

  always #5 clk = ~clk;

  gamma_lut_pingpong #(.IN_W(IN_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .host_idx_load(host_idx_load), .host_idx(host_idx),
    .host_data_wr(host_data_wr), .host_data(host_data),
    .host_wr_mask(host_wr_mask), .host_ram_sel(host_ram_sel),
    .mode_req(mode_req), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .lut_status(lut_status)
  );

  int dir_checks = 0, dir_fails = 0;
  int mdl_checks = 0, mdl_fails = 0;
  bit done = 0;

  function automatic int fa(int i, int c); return (i * 16 + c * 5 + 1) & 12'hFFF; endfunction
  function automatic int fb(int i, int c); return (4095 - i * 16 - c * 3) & 12'hFFF; endfunction
  function automatic int stat_of(int m); return (m == 2) ? 1 : (m == 3) ? 2 : 0; endfunction

  // ---------------- reference model ----------------
  int mem_m [2][3][256];
  int m_valid = 0, m_mode = 0, m_idx = 0, m_ph = 0;
  int m_out [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_mode = 0; m_idx = 0; m_ph = 0;
    end else begin
      if (pix_valid && (m_valid == 0 || out_ready)) begin
        for (int c = 0; c < 3; c++) begin
          int id;
          id = (c == 0) ? int'(pix_r[9:2]) : (c == 1) ? int'(pix_g[9:2]) : int'(pix_b[9:2]);
          if (m_mode == 2)      m_out[c] = mem_m[0][c][id];
          else if (m_mode == 3) m_out[c] = mem_m[1][c][id];
          else                  m_out[c] = id * 16;
        end
        m_valid = 1;
      end else if (out_ready) begin
        m_valid = 0;
      end
      if (frame_start) m_mode = int'(mode_req);
      if (host_idx_load) begin
        m_idx = int'(host_idx); m_ph = 0;
      end else if (host_data_wr) begin
        if (host_wr_mask[m_ph]) mem_m[host_ram_sel][m_ph][m_idx] = int'(host_data);
        if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
        else m_ph = m_ph + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      mdl_checks++;
      if (int'(out_valid) != m_valid) begin
        mdl_fails++; $display("FAIL R9 out_valid act=%0d exp=%0d", out_valid, m_valid);
      end
      mdl_checks++;
      if (int'(lut_status) != stat_of(m_mode)) begin
        mdl_fails++; $display("FAIL R7 status act=%0d exp=%0d", lut_status, stat_of(m_mode));
      end
      mdl_checks++;
      if (pix_ready != (m_valid == 0 || out_ready)) begin
        mdl_fails++; $display("FAIL R10 pix_ready act=%0d exp=%0d", pix_ready, (m_valid == 0 || out_ready));
      end
      if (m_valid != 0) begin
        mdl_checks++;
        if (int'(out_r) != m_out[0] || int'(out_g) != m_out[1] || int'(out_b) != m_out[2]) begin
          mdl_fails++;
          $display("FAIL R5/R8 data act=%h %h %h exp=%h %h %h", out_r, out_g, out_b,
                   m_out[0], m_out[1], m_out[2]);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input string tag, input int act, input int exp);
    dir_checks++;
    if (act != exp) begin
      dir_fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); #2; endtask

  task automatic load_idx(input int i);
    host_idx_load = 1'b1; host_idx = 8'(i); step(); host_idx_load = 1'b0;
  endtask

  task automatic put(input int d);
    host_data_wr = 1'b1; host_data = 12'(d); step(); host_data_wr = 1'b0;
  endtask

  task automatic sof(input int m);
    mode_req = 2'(m); frame_start = 1'b1; step(); frame_start = 1'b0;
  endtask

  task automatic px(input int r, input int g, input int b, output int orr, output int og, output int ob);
    pix_valid = 1'b1; pix_r = IN_W'(r); pix_g = IN_W'(g); pix_b = IN_W'(b);
    @(negedge clk);
    orr = int'(out_r); og = int'(out_g); ob = int'(out_b);
    #2; pix_valid = 1'b0;
  endtask

  task automatic fill(input int sel);
    host_ram_sel = sel[0]; host_wr_mask = 3'd7; load_idx(0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++)
        put(sel == 0 ? fa(i, c) : fb(i, c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", (dir_checks + mdl_checks) - (dir_fails + mdl_fails + 1),
               dir_checks + mdl_checks + 1);
      $finish;
    end
  end

  initial begin
    int r, g, b;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 status in reset", int'(lut_status), 0);
    #2; rst_n = 1'b1;
    step();
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 status after reset", int'(lut_status), 0);

    fill(0);
    fill(1);

    // R8: bypass
    px(10'h3FF, 10'h005, 10'h102, r, g, b);
    chk("R8 bypass r", r, 12'hFF0);
    chk("R8 bypass g", g, 12'h010);
    chk("R8 bypass b", b, 12'h400);

    // R6: request without frame strobe stays in bypass
    mode_req = 2'd2; step();
    chk("R6 status before strobe", int'(lut_status), 0);
    px(10'h0AB, 10'h0AB, 10'h0AB, r, g, b);
    chk("R6 still bypass", r, 12'h2A0);

    sof(2);
    chk("R7 status table A", int'(lut_status), 1);
    // R5: table A, low input bits ignored
    px((7 << 2) | 3, (8 << 2) | 1, (9 << 2) | 2, r, g, b);
    chk("R5 table A r", r, fa(7, 0));
    chk("R5 table A g", g, fa(8, 1));
    chk("R5 table A b", b, fa(9, 2));

    // R11: write the idle table B while A is applied
    host_ram_sel = 1'b1; host_wr_mask = 3'd7; load_idx(5);
    put(1); put(2); put(3);
    px(5 << 2, 5 << 2, 5 << 2, r, g, b);
    chk("R11 table A unaffected r", r, fa(5, 0));
    chk("R11 table A unaffected b", b, fa(5, 2));

    // R4: switch to table B and see the host-selected writes
    sof(3);
    chk("R7 status table B", int'(lut_status), 2);
    px(5 << 2, 5 << 2, 5 << 2, r, g, b);
    chk("R4 table B idx5 r", r, 1);
    chk("R4 table B idx5 g", g, 2);
    chk("R4 table B idx5 b", b, 3);
    px(9 << 2, 9 << 2, 9 << 2, r, g, b);
    chk("R5 table B g", g, fb(9, 1));

    // R3: mask only green, sequence still advances
    host_ram_sel = 1'b0; load_idx(5);
    host_wr_mask = 3'b010; put(100); put(200); put(300);
    host_wr_mask = 3'b111; put(7); put(8); put(9);
    sof(2);
    px(5 << 2, 5 << 2, 5 << 2, r, g, b);
    chk("R3 masked r kept", r, fa(5, 0));
    chk("R3 green written", g, 200);
    chk("R3 masked b kept", b, fa(5, 2));
    px(6 << 2, 6 << 2, 6 << 2, r, g, b);
    chk("R2 next index r", r, 7);
    chk("R2 next index b", b, 9);

    // R2: wrap 255 -> 0
    load_idx(255);
    put(11); put(12); put(13); put(21); put(22); put(23);
    px(255 << 2, 255 << 2, 255 << 2, r, g, b);
    chk("R2 idx255 g", g, 12);
    px(0, 0, 0, r, g, b);
    chk("R2 wrapped idx0 r", r, 21);
    chk("R2 wrapped idx0 b", b, 23);

    // R7: code 1 behaves as bypass
    sof(1);
    chk("R7 code1 status", int'(lut_status), 0);
    px(10'h2A4, 10'h2A4, 10'h2A4, r, g, b);
    chk("R7 code1 bypass", r, 12'hA90);

    // R10: back-pressure
    out_ready = 1'b0; pix_valid = 1'b1;
    pix_r = 10'h2A4; pix_g = 10'h2A4; pix_b = 10'h2A4;
    @(negedge clk);
    chk("R9 valid after accept", int'(out_valid), 1);
    #2; pix_r = 10'h10C; pix_g = 10'h10C; pix_b = 10'h10C;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held data", int'(out_r), 12'hA90);
      chk("R10 ready low", int'(pix_ready), 0);
    end
    #2; out_ready = 1'b1;
    @(negedge clk);
    chk("R10 next pixel after drain", int'(out_r), 12'h430);
    #2; pix_valid = 1'b0;
    step(); step();
    chk("R9 drained", int'(out_valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", (dir_checks + mdl_checks) - (dir_fails + mdl_fails),
             dir_checks + mdl_checks);
    $finish;
  end
endmodule